// File: doc/BRIEF.md
# OFDM Symbol Deinterleaver with Depuncturing

This block sits between the constellation demapper and the convolutional decoder of an OFDM receiver. The demapper writes one data sub-carrier per cycle as a 6-bit word. Bit `b` of the word at position `a` carries the received coded bit `a*N_BPSC + b`. The block keeps the whole symbol in a small two-port store. Once the symbol is complete, it walks the coded bits in their original transmit order, undoing both interleaver permutations, and emits them two per clock as one A/B pair of the mother code.

For punctured code rates (2/3, 3/4 and 5/6), the block inserts a dummy bit wherever the transmitter dropped one and raises that bit's erase flag. The decoder behind it therefore always sees a uniform rate-1/2 pair stream. Legacy 20 MHz symbols (48 sub-carriers, 16 interleaver columns) and single-stream HT 20 MHz symbols (52 sub-carriers, 13 columns) are both handled. A 5-bit mode key written alongside the first sub-carrier of each symbol selects the variant.

The read order is not stored as a table. It is produced by a permutation function evaluated twice per cycle, once for the A bit and once for the B bit.

Top module: `deint_depuncture`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `out_last`, `out_bits` and `out_erase` are 0, and the block waits for the first sub-carrier of a symbol.
- R2: The mode key selects modulation and code rate. With key bit 4 low, the low four bits select a legacy mode: 1101 BPSK 1/2, 1111 BPSK 3/4, 0101 QPSK 1/2, 0111 QPSK 3/4, 1001 16-QAM 1/2, 1011 16-QAM 3/4, 0001 64-QAM 2/3, 0011 64-QAM 3/4. With key bit 4 high, the low bits are an HT index 0..7 selecting, in order, BPSK 1/2, QPSK 1/2, QPSK 3/4, 16-QAM 1/2, 16-QAM 3/4, 64-QAM 2/3, 64-QAM 3/4, 64-QAM 5/6.
- R3: Bit `b` of the word written at position `a` is received coded bit `j = a*N_BPSC + b` (N_BPSC = 1, 2, 4, 6). Word bits at positions N_BPSC and above have no effect on any output.
- R4: A symbol is exactly 48 accepted writes (legacy) or 52 (HT). `out_valid` stays low while writes are collected and in the cycle after the edge that accepts the last write. The first output pair appears after the following edge.
- R5: Output bits follow the original coded order k. Received index j maps back to k through i = s*floor(j/s) + (j + floor(N_COL*j/N_CBPS)) mod s, with s = max(N_BPSC/2, 1), and then k = N_COL*i - (N_CBPS-1)*floor(i/N_ROW). N_COL is 16 (legacy) or 13 (HT), N_ROW is 3*N_BPSC (legacy) or 4*N_BPSC (HT), and N_CBPS is N_COL*N_ROW.
- R6: `out_bits[0]`/`out_erase[0]` are the A bit of a pair and `out_bits[1]`/`out_erase[1]` are the B bit. Within each puncturing period, the pattern of kept bits depends on the code rate:
  - 1/2: every bit is kept.
  - 2/3: A1 B1 A2 are kept.
  - 3/4: A1 B1 A2 B3 are kept.
  - 5/6: A1 B1 A2 B3 A4 B5 are kept.
  
  Every other position is output as 0 with its erase flag set to 1.
- R7: Each symbol produces exactly N_DBPS pairs on consecutive cycles. `out_last` is high only on the final pair, and `out_valid` is low in the cycle after it.
- R8: Write strobes that arrive while a symbol is being read out are ignored and do not count towards the next symbol.
- R9: The mode key is sampled only with the first write of a symbol. Changes to it during the rest of that symbol's writes or its read-out have no effect.
- R10: Any key not listed in R2 behaves as legacy BPSK rate 1/2 (key 01101).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Sub-carrier word strobe |
| wr_data | input | 6 | Demapped bits of one sub-carrier, low N_BPSC valid |
| key | input | 5 | Mode key, sampled with the first write of a symbol |
| out_valid | output | 1 | An output pair is present |
| out_bits | output | 2 | Coded pair: bit 0 = A, bit 1 = B |
| out_erase | output | 2 | Erase flag per output bit |
| out_last | output | 1 | Final pair of the symbol |

## Verification
Every legal legacy and HT mode is run with pseudo-random coded bits. The words are packed through the inverse permutation formulas, and garbage is placed in the unused upper bits, so a wrong column count, a wrong row count or a wrong in-word bit position shows up as a data mismatch. The lower-order modulations separate bit-position faults from permutation faults, and the punctured modes separate errors in the erasure pattern from errors in the coded-bit order. Dedicated symbols do three further things. They toggle the key after the first write, which only a correctly latched mode survives. They drive write strobes throughout a read-out, which would shift the following symbol if accepted. They use unlisted keys, which must fall back to legacy BPSK 1/2.

// File: rtl/deint_pkg.sv
package deint_pkg;
  localparam int BIT_W    = 6;
  localparam int LEG_SC   = 48;
  localparam int HT_SC    = 52;
  localparam int LEG_COLS = 16;
  localparam int HT_COLS  = 13;
  localparam int LEG_ROWF = 3;
  localparam int HT_ROWF  = 4;
  localparam int MAX_SC   = HT_SC;
  localparam int MAX_CBPS = MAX_SC * BIT_W;
  localparam int K_W      = $clog2(MAX_CBPS + 2);
  localparam int A_W      = $clog2(MAX_SC);
  localparam int B_W      = $clog2(BIT_W);
  localparam int KEY_W    = 5;

  typedef enum logic [1:0] {CR_1_2, CR_2_3, CR_3_4, CR_5_6} crate_e;

  typedef struct packed {
    logic       ht;
    logic [2:0] nbpsc;
    crate_e     crate;
  } mode_t;

  typedef struct packed {
    logic [A_W-1:0] addr;
    logic [B_W-1:0] bitp;
  } loc_t;

  function automatic mode_t mk_mode(input logic ht, input int nb, input crate_e cr);
    mode_t m;
    m.ht    = ht;
    m.nbpsc = 3'(nb);
    m.crate = cr;
    return m;
  endfunction

  // Key decode; unlisted keys fall back to legacy BPSK 1/2 (R2, R10)
  function automatic mode_t decode_key(input logic [KEY_W-1:0] k);
    mode_t m;
    m = mk_mode(1'b0, 1, CR_1_2);
    if (k[4]) begin
      case (k[3:0])
        4'd0: m = mk_mode(1'b1, 1, CR_1_2);
        4'd1: m = mk_mode(1'b1, 2, CR_1_2);
        4'd2: m = mk_mode(1'b1, 2, CR_3_4);
        4'd3: m = mk_mode(1'b1, 4, CR_1_2);
        4'd4: m = mk_mode(1'b1, 4, CR_3_4);
        4'd5: m = mk_mode(1'b1, 6, CR_2_3);
        4'd6: m = mk_mode(1'b1, 6, CR_3_4);
        4'd7: m = mk_mode(1'b1, 6, CR_5_6);
        default: ;
      endcase
    end else begin
      case (k[3:0])
        4'b1101: m = mk_mode(1'b0, 1, CR_1_2);
        4'b1111: m = mk_mode(1'b0, 1, CR_3_4);
        4'b0101: m = mk_mode(1'b0, 2, CR_1_2);
        4'b0111: m = mk_mode(1'b0, 2, CR_3_4);
        4'b1001: m = mk_mode(1'b0, 4, CR_1_2);
        4'b1011: m = mk_mode(1'b0, 4, CR_3_4);
        4'b0001: m = mk_mode(1'b0, 6, CR_2_3);
        4'b0011: m = mk_mode(1'b0, 6, CR_3_4);
        default: ;
      endcase
    end
    return m;
  endfunction

  function automatic int safe_nb(input mode_t m);
    return (m.nbpsc == 3'd0) ? 1 : int'(m.nbpsc);
  endfunction

  function automatic int sc_per_sym(input mode_t m);
    return m.ht ? HT_SC : LEG_SC;
  endfunction

  function automatic int n_cbps(input mode_t m);
    return sc_per_sym(m) * safe_nb(m);
  endfunction

  // Forward interleave of coded index k to its received index, then to a buffer location
  function automatic loc_t bit_loc(input int k, input mode_t m);
    int nb, ncol, nrow, s, col, row, i, j;
    loc_t l;
    nb   = safe_nb(m);
    ncol = m.ht ? HT_COLS : LEG_COLS;
    nrow = (m.ht ? HT_ROWF : LEG_ROWF) * nb;
    s    = (nb > 1) ? nb / 2 : 1;
    col  = k % ncol;
    row  = k / ncol;
    i    = nrow * col + row;
    j    = (i - (i % s)) + ((i - col) % s);
    l.addr = A_W'(j / nb);
    l.bitp = B_W'(j % nb);
    return l;
  endfunction

  function automatic int punc_period(input crate_e cr);
    case (cr)
      CR_2_3:  return 2;
      CR_3_4:  return 3;
      CR_5_6:  return 5;
      default: return 1;
    endcase
  endfunction

  // {take_b, take_a}: phase 0 keeps both, odd phases keep A, even non-zero keep B
  function automatic logic [1:0] punc_take(input crate_e cr, input logic [2:0] ph);
    if (cr == CR_1_2 || ph == 3'd0) return 2'b11;
    return ph[0] ? 2'b01 : 2'b10;
  endfunction

  function automatic logic pick_bit(input logic [BIT_W-1:0] w, input logic [B_W-1:0] p);
    logic r;
    r = 1'b0;
    for (int n = 0; n < BIT_W; n++)
      if (int'(p) == n) r = w[n];
    return r;
  endfunction
endpackage

// File: rtl/deint_buf.sv
module deint_buf #(
  parameter int DEPTH = 52,
  parameter int WIDTH = 6,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [WIDTH-1:0] rd_data_a,
  output logic [WIDTH-1:0] rd_data_b
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && int'(wr_addr) < DEPTH) mem[wr_addr] <= wr_data;
  end

  assign rd_data_a = (int'(rd_addr_a) < DEPTH) ? mem[rd_addr_a] : '0;
  assign rd_data_b = (int'(rd_addr_b) < DEPTH) ? mem[rd_addr_b] : '0;
endmodule

// File: rtl/deint_seq.sv
module deint_seq
  import deint_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  mode_t            mode,
  output logic [A_W-1:0]   rd_addr_a,
  output logic [A_W-1:0]   rd_addr_b,
  input  logic [BIT_W-1:0] rd_word_a,
  input  logic [BIT_W-1:0] rd_word_b,
  output logic [1:0]       step_bits,
  output logic [1:0]       step_erase,
  output logic             step_last
);
  logic [K_W-1:0] kptr, k_next;
  logic [2:0]     phase, phase_next;
  logic           take_a, take_b;
  loc_t           loc_a, loc_b;

  always_comb begin
    {take_b, take_a} = punc_take(mode.crate, phase);
    loc_a      = bit_loc(int'(kptr), mode);
    loc_b      = bit_loc(int'(kptr) + (take_a ? 1 : 0), mode);
    rd_addr_a  = loc_a.addr;
    rd_addr_b  = loc_b.addr;
    step_bits  = {take_b & pick_bit(rd_word_b, loc_b.bitp),
                  take_a & pick_bit(rd_word_a, loc_a.bitp)};
    step_erase = {~take_b, ~take_a};
    k_next     = kptr + K_W'(take_a) + K_W'(take_b);
    step_last  = (int'(k_next) == n_cbps(mode));
    phase_next = (int'(phase) == punc_period(mode.crate) - 1) ? 3'd0 : phase + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kptr  <= '0;
      phase <= '0;
    end else if (advance) begin
      kptr  <= step_last ? '0 : k_next;
      phase <= step_last ? 3'd0 : phase_next;
    end
  end

  AST_K_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(kptr) < n_cbps(mode)) else $error("coded index past symbol end"); // R5
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase) < punc_period(mode.crate)) else $error("puncture phase out of period"); // R6
endmodule

// File: rtl/deint_depuncture.sv
module deint_depuncture
  import deint_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [BIT_W-1:0] wr_data,
  input  logic [KEY_W-1:0] key,
  output logic             out_valid,
  output logic [1:0]       out_bits,
  output logic [1:0]       out_erase,
  output logic             out_last
);
  logic           st_drain;
  logic [A_W-1:0] wptr;
  mode_t          mode_q, mode_in, mode_use;
  logic           wr_accept, sym_full, step_fire;
  logic [A_W-1:0] rd_addr_a, rd_addr_b;
  logic [BIT_W-1:0] rd_word_a, rd_word_b;
  logic [1:0]     seq_bits, seq_erase;
  logic           seq_last;

  assign mode_in   = decode_key(key);
  assign mode_use  = (wptr == '0) ? mode_in : mode_q;
  assign wr_accept = wr_valid & ~st_drain;
  assign sym_full  = wr_accept && (int'(wptr) == sc_per_sym(mode_use) - 1);
  assign step_fire = st_drain;

  deint_buf #(.DEPTH(MAX_SC), .WIDTH(BIT_W)) u_buf (
    .clk       (clk),
    .wr_en     (wr_accept),
    .wr_addr   (wptr),
    .wr_data   (wr_data),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_a (rd_word_a),
    .rd_data_b (rd_word_b)
  );

  deint_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (step_fire),
    .mode       (mode_q),
    .rd_addr_a  (rd_addr_a),
    .rd_addr_b  (rd_addr_b),
    .rd_word_a  (rd_word_a),
    .rd_word_b  (rd_word_b),
    .step_bits  (seq_bits),
    .step_erase (seq_erase),
    .step_last  (seq_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_drain  <= 1'b0;
      wptr      <= '0;
      mode_q    <= mk_mode(1'b0, 1, CR_1_2);
      out_valid <= 1'b0;
      out_bits  <= '0;
      out_erase <= '0;
      out_last  <= 1'b0;
    end else begin
      if (wr_accept) begin
        wptr <= sym_full ? '0 : wptr + 1'b1;
        if (wptr == '0) mode_q <= mode_in;
      end
      if (sym_full) st_drain <= 1'b1;
      else if (step_fire && seq_last) st_drain <= 1'b0;
      out_valid <= step_fire;
      out_bits  <= step_fire ? seq_bits  : 2'b00;
      out_erase <= step_fire ? seq_erase : 2'b00;
      out_last  <= step_fire & seq_last;
    end
  end

  AST_WPTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr != '0) |-> int'(wptr) < sc_per_sym(mode_q)) else $error("write pointer beyond symbol"); // R4
  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(st_drain)) else $error("output before symbol complete"); // R4
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid) else $error("output continues after last pair"); // R7
  AST_ERASED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bits & out_erase) == 2'b00) else $error("erased bit not zero"); // R6
  AST_ONE_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_erase != 2'b11) else $error("both bits of a pair erased"); // R6
  AST_DRAIN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_drain && $past(st_drain)) |-> $stable(wptr)) else $error("write taken during read-out"); // R8
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_drain && $past(st_drain)) |-> $stable(mode_q)) else $error("mode changed mid symbol"); // R9
endmodule

// File: tb/tb_deint_depuncture.sv
module tb_deint_depuncture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [5:0] wr_data = '0;
  logic [4:0] key = '0;
  logic       out_valid, out_last;
  logic [1:0] out_bits, out_erase;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  deint_depuncture dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .key(key),
    .out_valid(out_valid), .out_bits(out_bits), .out_erase(out_erase), .out_last(out_last)
  );

  bit         cbits [0:311];
  logic [5:0] words [0:51];
  bit         xa [0:299], xb [0:299], ea [0:299], eb [0:299];
  int         nsteps, nsc, cur_nb;
  int unsigned lfsr;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void bmode(input logic [4:0] k, output int nb, output int ht, output int rc);
    ht = 0; nb = 1; rc = 0;
    if (k[4]) begin
      case (k[3:0])
        4'd0: begin ht = 1; nb = 1; rc = 0; end
        4'd1: begin ht = 1; nb = 2; rc = 0; end
        4'd2: begin ht = 1; nb = 2; rc = 2; end
        4'd3: begin ht = 1; nb = 4; rc = 0; end
        4'd4: begin ht = 1; nb = 4; rc = 2; end
        4'd5: begin ht = 1; nb = 6; rc = 1; end
        4'd6: begin ht = 1; nb = 6; rc = 2; end
        4'd7: begin ht = 1; nb = 6; rc = 3; end
        default: ;
      endcase
    end else begin
      case (k[3:0])
        4'hD: begin nb = 1; rc = 0; end
        4'hF: begin nb = 1; rc = 2; end
        4'h5: begin nb = 2; rc = 0; end
        4'h7: begin nb = 2; rc = 2; end
        4'h9: begin nb = 4; rc = 0; end
        4'hB: begin nb = 4; rc = 2; end
        4'h1: begin nb = 6; rc = 1; end
        4'h3: begin nb = 6; rc = 2; end
        default: ;
      endcase
    end
  endfunction

  // keep mask over the mother-code stream A1 B1 A2 B2 ...
  function automatic bit keep(input int rc, input int p);
    int m;
    case (rc)
      1: begin m = p % 4;  return (m < 3); end
      2: begin m = p % 6;  return (m < 3) || (m == 5); end
      3: begin m = p % 10; return (m < 3) || (m == 5) || (m == 6) || (m == 9); end
      default: return 1'b1;
    endcase
  endfunction

  task automatic prep(input logic [4:0] k, input int seed);
    int nb, ht, rc, ncol, nrow, ncbps, s, idx, p;
    bmode(k, nb, ht, rc);
    cur_nb = nb;
    ncol   = ht ? 13 : 16;
    nrow   = (ht ? 4 : 3) * nb;
    ncbps  = (ht ? 52 : 48) * nb;
    nsc    = ht ? 52 : 48;
    s      = (nb > 1) ? nb / 2 : 1;
    lfsr   = seed;
    for (int n = 0; n < ncbps; n++) begin
      lfsr = lfsr * 1103515245 + 12345;
      cbits[n] = lfsr[16];
    end
    for (int w = 0; w < 52; w++) words[w] = 6'(w * 7 + seed) | 6'h30;
    for (int j = 0; j < ncbps; j++) begin
      int ii, kk;
      ii = s * (j / s) + (j + (ncol * j) / ncbps) % s;
      kk = ncol * ii - (ncbps - 1) * (ii / nrow);
      words[j / nb][j % nb] = cbits[kk];
    end
    idx = 0; p = 0; nsteps = 0;
    while (idx < ncbps || (p % 2) != 0) begin
      bit kp, v, er;
      kp = keep(rc, p);
      v = 1'b0; er = 1'b1;
      if (kp) begin v = cbits[idx]; idx++; er = 1'b0; end
      if (p % 2 == 0) begin xa[nsteps] = v; ea[nsteps] = er; end
      else begin xb[nsteps] = v; eb[nsteps] = er; nsteps++; end
      p++;
    end
  endtask

  task automatic run_sym(input logic [4:0] k, input int seed, input logic [4:0] other,
                         input bit chg, input bit garb, input string tagv, input string tagd);
    string td;
    prep(k, seed);
    td = tagd;
    if (td == "") td = (cur_nb < 6) ? "R3" : "R5";
    for (int w = 0; w < nsc; w++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R4", "out_valid during fill", int'(out_valid), 0);
      wr_valid = 1'b1;
      wr_data  = words[w];
      key      = (chg && w > 0) ? other : k;
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R4", "out_valid right after last write", int'(out_valid), 0);
    wr_valid = garb;
    wr_data  = 6'h2A;
    if (chg) key = other;
    for (int st = 0; st < nsteps; st++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, tagv, "out_valid during read-out", int'(out_valid), 1);
      chk(out_bits == {xb[st], xa[st]}, td, "pair bits", int'(out_bits), int'({xb[st], xa[st]}));
      chk(out_erase == {eb[st], ea[st]}, "R6", "erase flags", int'(out_erase), int'({eb[st], ea[st]}));
      chk(out_last == (st == nsteps - 1), "R7", "last flag", int'(out_last), int'(st == nsteps - 1));
      wr_valid = garb && (st < nsteps - 2);
      wr_data  = 6'(st);
    end
    @(negedge clk);
    wr_valid = 1'b0;
    chk(out_valid == 1'b0, "R7", "out_valid after last pair", int'(out_valid), 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [4:0] leg [8];
    leg = '{5'h0D, 5'h0F, 5'h05, 5'h07, 5'h09, 5'h0B, 5'h01, 5'h03};
    repeat (4) begin
      @(negedge clk);
      chk(out_valid == 1'b0 && out_last == 1'b0, "R1", "valid/last in reset", int'({out_valid, out_last}), 0);
      chk(out_bits == 2'b00 && out_erase == 2'b00, "R1", "bits/erase in reset", int'({out_bits, out_erase}), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    // every legacy mode (R2), two data patterns each
    for (int m = 0; m < 8; m++) begin
      run_sym(leg[m], 11 + m, leg[m], 1'b0, 1'b0, "R2", "");
      run_sym(leg[m], 97 + 3 * m, leg[m], 1'b0, 1'b0, "R2", "");
    end
    // every HT mode (R2)
    for (int m = 0; m < 8; m++) begin
      run_sym(5'(16 + m), 201 + m, 5'(16 + m), 1'b0, 1'b0, "R2", "");
      run_sym(5'(16 + m), 333 + 5 * m, 5'(16 + m), 1'b0, 1'b0, "R2", "");
    end
    // unlisted keys fall back to legacy BPSK 1/2 (R10)
    run_sym(5'h00, 41, 5'h00, 1'b0, 1'b0, "R10", "R10");
    run_sym(5'h1C, 42, 5'h1C, 1'b0, 1'b0, "R10", "R10");
    // strobes during read-out, then a clean symbol that must be aligned (R8)
    run_sym(5'h17, 55, 5'h17, 1'b0, 1'b1, "R2", "");
    run_sym(5'h0B, 56, 5'h0B, 1'b0, 1'b0, "R8", "R8");
    run_sym(5'h03, 57, 5'h03, 1'b0, 1'b1, "R2", "");
    run_sym(5'h0D, 58, 5'h0D, 1'b0, 1'b0, "R8", "R8");
    // key changed after first write (R9)
    run_sym(5'h0B, 61, 5'h17, 1'b1, 1'b0, "R9", "R9");
    run_sym(5'h12, 62, 5'h01, 1'b1, 1'b0, "R9", "R9");
    finish_run();
  end
endmodule